// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter Stage

This block is one stage of a synchronous binary counter, four bits wide by default. On each rising clock edge it loads a parallel value, increments, decrements or holds. The choice depends on an active-low load strobe, two active-low count enables and a direction input. Load has priority over both enables. The count moves only when both enables are LOW. The count wraps at either end of its range.

An active-low carry output is decoded combinationally from the present count, the direction input and the second enable (the "chain" enable). It goes LOW only while the chain enable is LOW. When counting up it goes LOW at the all-ones count, and when counting down at zero. Several stages share the clock, load, direction and first enable (the "local" enable). Each stage's carry drives the chain enable of the next stage, which gives a fully synchronous counter of any width with no extra gating. The block has no reset. It is initialized with a synchronous load.

Top module: `updn_stage`

## Requirements
- R1: With `ld_n` LOW at a rising edge, `q` takes `din` after that edge, whatever `en_loc_n`, `en_chn_n` and `up` are.
- R2: With `ld_n` HIGH and either `en_loc_n` or `en_chn_n` HIGH at a rising edge, `q` keeps its value.
- R3: With `ld_n` HIGH, both enables LOW and `up` HIGH, `q` increments by one at the edge, and the all-ones count wraps to zero.
- R4: With `ld_n` HIGH, both enables LOW and `up` LOW, `q` decrements by one at the edge, and zero wraps to all-ones.
- R5: `rc_n` is LOW exactly when `en_chn_n` is LOW and either `up` is HIGH with `q` all-ones, or `up` is LOW with `q` zero. Otherwise it is HIGH.
- R6: `rc_n` follows a change of `up` or `en_chn_n` within the same clock cycle, with no clock edge needed, and that change does not alter `q`.
- R7: Three stages that share `clk`, `ld_n`, `en_loc_n` and `up`, with each stage's `rc_n` driving the next stage's `en_chn_n`, count as one 12-bit counter. This holds for loading, holding, and both directions, and includes carry and borrow across stage boundaries and the 12-bit wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| ld_n | input | 1 | Synchronous parallel load, active LOW, highest priority |
| en_loc_n | input | 1 | Local count enable, active LOW |
| en_chn_n | input | 1 | Chain count enable, active LOW; also gates the carry |
| up | input | 1 | Direction: HIGH counts up, LOW counts down |
| din | input | W (4) | Parallel preset value |
| q | output | W (4) | Present count |
| rc_n | output | 1 | Terminal-count carry, active LOW, combinational |

## Verification
A wrong count register shows at `q` one edge after the load, hold or count that went wrong. It also shows at `rc_n` at once if the bad value sits at a terminal count. In a chain, a stage that decodes its carry wrongly corrupts the upper bits only at a carry or borrow boundary. So the bench loads values next to the boundaries, such as 0x0FE, 0x100 and 0xFFF, and checks the full 12-bit value after every edge. Direction and enable flips are checked in the same cycle, before the next edge, so that a carry registered by mistake shows up as a one-cycle lag.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_LOAD = 2'd1,
        STEP_INC  = 2'd2,
        STEP_DEC  = 2'd3
    } step_e;
endpackage

// File: rtl/updn_mode_dec.sv
`timescale 1ns/1ps
module updn_mode_dec
    import updn_pkg::*;
(
    input  logic  ld_n,
    input  logic  en_loc_n,
    input  logic  en_chn_n,
    input  logic  up,
    output step_e step
);
    always_comb begin
        if (!ld_n) begin
            step = STEP_LOAD;
        end else if (en_loc_n || en_chn_n) begin
            step = STEP_HOLD;
        end else if (up) begin
            step = STEP_INC;
        end else begin
            step = STEP_DEC;
        end
    end
endmodule

// File: rtl/updn_next.sv
`timescale 1ns/1ps
module updn_next
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  step_e          step,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (step)
            STEP_LOAD: nxt = din;
            STEP_INC:  nxt = cur + ONE;
            STEP_DEC:  nxt = cur - ONE;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/updn_carry.sv
`timescale 1ns/1ps
module updn_carry #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    input  logic         en_chn_n,
    output logic         rc_n
);
    logic at_top;
    logic at_bot;

    always_comb begin
        at_top = &cur;
        at_bot = ~|cur;
        rc_n   = !(!en_chn_n && (up ? at_top : at_bot));
    end
endmodule

// File: rtl/updn_stage.sv
`timescale 1ns/1ps
module updn_stage
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         ld_n,
    input  logic         en_loc_n,
    input  logic         en_chn_n,
    input  logic         up,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         rc_n
);
    typedef struct packed {
        logic [W-1:0] count;
    } stage_t;

    stage_t       st_d;
    stage_t       st_q;
    step_e        step;
    logic [W-1:0] nxt;

    updn_mode_dec u_dec (
        .ld_n     (ld_n),
        .en_loc_n (en_loc_n),
        .en_chn_n (en_chn_n),
        .up       (up),
        .step     (step)
    );

    updn_next #(.W(W)) u_next (
        .step (step),
        .cur  (st_q.count),
        .din  (din),
        .nxt  (nxt)
    );

    updn_carry #(.W(W)) u_carry (
        .cur      (st_q.count),
        .up       (up),
        .en_chn_n (en_chn_n),
        .rc_n     (rc_n)
    );

    always_comb begin
        st_d       = st_q;
        st_d.count = nxt;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.count;
endmodule

// File: rtl/updn_stage_chk.sv
`timescale 1ns/1ps
module updn_stage_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         ld_n,
    input logic         en_loc_n,
    input logic         en_chn_n,
    input logic         up,
    input logic [W-1:0] din,
    input logic [W-1:0] q,
    input logic         rc_n
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    // Count is unknown until the first load; checks start after it.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        armed_q <= armed_q | !ld_n;
    end

    p_load_r1: assert property (@(posedge clk) disable iff (!armed_q)
        !ld_n |=> q == $past(din));

    p_hold_r2: assert property (@(posedge clk) disable iff (!armed_q)
        (ld_n && (en_loc_n || en_chn_n)) |=> $stable(q));

    p_inc_r3: assert property (@(posedge clk) disable iff (!armed_q)
        (ld_n && !en_loc_n && !en_chn_n && up) |=> q == $past(q) + ONE);

    p_dec_r4: assert property (@(posedge clk) disable iff (!armed_q)
        (ld_n && !en_loc_n && !en_chn_n && !up) |=> q == $past(q) - ONE);

    p_wrap_up_r3: assert property (@(posedge clk) disable iff (!armed_q)
        (ld_n && !en_loc_n && !rc_n && up) |=> q == '0);

    p_wrap_dn_r4: assert property (@(posedge clk) disable iff (!armed_q)
        (ld_n && !en_loc_n && !rc_n && !up) |=> q == ALL1);

    p_chain_gate_r5: assert property (@(posedge clk) disable iff (!armed_q)
        en_chn_n |-> rc_n);
endmodule

bind updn_stage updn_stage_chk #(.W(W)) u_chk (
    .clk      (clk),
    .ld_n     (ld_n),
    .en_loc_n (en_loc_n),
    .en_chn_n (en_chn_n),
    .up       (up),
    .din      (din),
    .q        (q),
    .rc_n     (rc_n)
);

// File: tb/sim_updn_stage.sv
`timescale 1ns/1ps
module sim_updn_stage;
    localparam int W  = 4;
    localparam int NS = 3;
    localparam int BW = W * NS;

    logic          clk = 1'b0;
    logic          ld_n = 1'b1;
    logic          en_loc_n = 1'b1;
    logic          en_chn_n = 1'b1;
    logic          up = 1'b1;
    logic [BW-1:0] din = '0;

    logic [W-1:0]  q0;
    logic          rc0;
    logic [BW-1:0] big_q;
    logic [NS-1:0] rc_c;
    logic [NS-1:0] t_c;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    updn_stage #(.W(W)) u0 (
        .clk(clk), .ld_n(ld_n), .en_loc_n(en_loc_n), .en_chn_n(en_chn_n),
        .up(up), .din(din[W-1:0]), .q(q0), .rc_n(rc0)
    );

    assign t_c[0] = en_chn_n;
    for (genvar i = 0; i < NS; i++) begin : g_casc
        if (i > 0) begin : g_link
            assign t_c[i] = rc_c[i-1];
        end
        updn_stage #(.W(W)) u_st (
            .clk(clk), .ld_n(ld_n), .en_loc_n(en_loc_n), .en_chn_n(t_c[i]),
            .up(up), .din(din[i*W +: W]), .q(big_q[i*W +: W]), .rc_n(rc_c[i])
        );
    end

    typedef struct {
        logic [W-1:0]  q4;
        logic          rc4;
        logic [BW-1:0] big;
        logic          rcbig;
        string         req;
    } item_t;

    item_t sb[$];

    logic [W-1:0]  ref4;
    logic [BW-1:0] refbig;

    task automatic chk(input string r, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    function automatic logic rc_exp4(logic [W-1:0] v, logic t, logic u);
        return !(!t && (u ? (v == {W{1'b1}}) : (v == '0)));
    endfunction

    function automatic logic rc_expbig(logic [BW-1:0] v, logic t, logic u);
        return !(!t && (u ? (v == {BW{1'b1}}) : (v == '0)));
    endfunction

    // Driver: apply inputs, check combinational carry before the edge,
    // then push the state expected after the coming edge.
    task automatic step(input logic l, input logic p, input logic t,
                        input logic u, input logic [BW-1:0] d, input string r);
        item_t it;
        @(posedge clk);
        #2;
        ld_n = l; en_loc_n = p; en_chn_n = t; up = u; din = d;
        #1;
        if (l) begin
            chk(r, "pre-edge rc_n single", {15'd0, rc0}, {15'd0, rc_exp4(ref4, t, u)});
            chk(r, "pre-edge rc_n chain", {15'd0, rc_c[NS-1]},
                {15'd0, rc_expbig(refbig, t, u)});
        end
        if (!l) begin
            ref4   = d[W-1:0];
            refbig = d;
        end else if (!p && !t) begin
            ref4   = u ? ref4 + 1'b1 : ref4 - 1'b1;
            refbig = u ? refbig + 1'b1 : refbig - 1'b1;
        end
        it.q4    = ref4;
        it.rc4   = rc_exp4(ref4, t, u);
        it.big   = refbig;
        it.rcbig = rc_expbig(refbig, t, u);
        it.req   = r;
        sb.push_back(it);
    endtask

    // Monitor: one edge after each push, compare the outputs.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk(it.req, "q single", {12'd0, q0}, {12'd0, it.q4});
                chk(it.req, "rc_n single", {15'd0, rc0}, {15'd0, it.rc4});
                chk(it.req, "q chain", {4'd0, big_q}, {4'd0, it.big});
                chk(it.req, "rc_n chain", {15'd0, rc_c[NS-1]}, {15'd0, it.rcbig});
            end
        end
    end

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=expired expected=done");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        ref4 = 'x;
        refbig = 'x;
        // R1: initial load sets the state
        step(1'b0, 1'b1, 1'b1, 1'b1, 12'h0A5, "R1");
        // R3: counting up
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, "R3");
        // R2: hold on either enable
        step(1'b1, 1'b1, 1'b0, 1'b1, 12'hFFF, "R2");
        step(1'b1, 1'b0, 1'b1, 1'b0, 12'hFFF, "R2");
        step(1'b1, 1'b1, 1'b1, 1'b0, 12'h123, "R2");
        // R3/R7: up across nibble and single-stage wrap
        step(1'b0, 1'b0, 1'b0, 1'b0, 12'h0FE, "R1");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, "R7");
        // R1: load beats enables while counting would be active
        step(1'b0, 1'b0, 1'b0, 1'b1, 12'h100, "R1");
        // R4/R7: down across borrow, single stage 0 -> F
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, "R4");
        // R6: direction flips at all-ones while held by local enable
        step(1'b0, 1'b1, 1'b1, 1'b1, 12'hFFF, "R1");
        step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R6");
        step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R5");
        step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R6");
        // R6: flips at zero
        step(1'b0, 1'b1, 1'b1, 1'b0, 12'h000, "R1");
        step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R6");
        step(1'b1, 1'b1, 1'b1, 1'b0, 12'h000, "R5");
        // R4: full down wrap of 12 bits
        step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, "R4");
        step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, "R4");
        // R3/R7: full up wrap of 12 bits
        step(1'b0, 1'b1, 1'b1, 1'b1, 12'hFFD, "R1");
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, "R3");
        // R7: long run through several carries
        step(1'b0, 1'b1, 1'b1, 1'b1, 12'h3F0, "R1");
        for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, "R7");
        for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, "R7");
        // R7: mixed sequence
        for (int k = 0; k < 300; k++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            step(r != 4'd0, r[1] & r[2], r[3] & r[0], r[2] | r[3],
                 12'($urandom_range(0, 4095)), "R7");
        end
        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule